// File: doc/BRIEF.md
# Debug TAP with Scan-Chain Selector

This block is the target side of a four-wire test access port for a debuggable processor core. It holds a 4-bit instruction register. It also holds a persistent 4-bit chain-select register, which is written through a dedicated select instruction. While a chain-access instruction is current, the selected internal scan chain is placed between TDI and TDO.

Three chains can be selected. Chain 0 spans the core periphery, data bus included, and chain 2 carries the debug registers; both live outside this block. This block sees only their serial outputs and drives their capture, shift and update strobes. Chain 1 is the core data bus plus a breakpoint bit. Its 33-bit shift path is held inside the block, so its length is fixed here. The port also provides a bypass bit, a 32-bit identification register, the boundary clamp and high-impedance instructions, and a restart request that the core receives while the restart instruction sits in Run-Test/Idle.

A debugger first selects a chain with the select instruction, then loads INTEST or EXTEST, then shifts data.

Top module: `dbg_tap_top`

## Requirements
- R1: The instruction register is 4 bits, shifted least significant bit first. Capture-IR loads 4'b0001. A newly shifted code becomes current only on leaving Update-IR.
- R2: Test-Logic-Reset makes IDCODE (4'hE) current. IDCODE selects a 32-bit register that captures ID_VALUE (bit 0 set) and shifts it out LSB first.
- R3: BYPASS (4'hF), every unassigned code, CLAMP (4'h5), HIGHZ (4'h7), CLAMPZ (4'h9) and RESTART (4'h4) select a 1-bit bypass register that captures 0.
- R4: SELECT (4'h2) puts a 4-bit shift stage behind TDI/TDO. The stage captures 4'b1000 and shifts LSB first. Its content moves into the held chain select only in Update-DR, and the held value survives all other instructions.
- R5: INTEST (4'hC) and EXTEST (4'h0) connect the chain numbered by the held select. Values 0, 1 and 2 are chains. Any other value gives bypass behaviour and no chain strobe.
- R6: Chain 1 is a 33-bit path: data shifted in reappears at TDO after 33 further shifts.
- R7: For chain 0 TDO follows periph_sdo, and for chain 2 it follows dbgreg_sdo.
- R8: chain_capture, chain_shift and chain_update are high only for the connected chain, in Capture-DR, Shift-DR and Update-DR respectively. At most one of the nine bits is high at any time.
- R9: restart_req is high during every TCK cycle spent in Run-Test/Idle while RESTART is current, and low otherwise.
- R10: Entering Test-Logic-Reset through TMS keeps the chain select. The asynchronous trst_n clears it to 0.
- R11: TDO changes only on the falling edge of TCK and is 0 outside Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| periph_sdo | input | 1 | Serial output of the periphery chain (chain 0) |
| dbgreg_sdo | input | 1 | Serial output of the debug register chain (chain 2) |
| tdo | output | 1 | Serial data out, falling-edge registered |
| restart_req | output | 1 | Restart request to the core |
| chain_capture | output | 3 | Per-chain capture strobe |
| chain_shift | output | 3 | Per-chain shift strobe |
| chain_update | output | 3 | Per-chain update strobe |

## Verification
The properties assume that TMS and TDI are stable around each rising TCK edge and that trst_n is only asserted while TCK is low. The stimulus meets both conditions by changing inputs shortly after a falling edge. They also assume that the external chain outputs change only between shifts. The bench holds periph_sdo and dbgreg_sdo constant throughout each scan. All TAP navigation follows legal state paths and ends in Run-Test/Idle. The one exception is a mid-run trst_n pulse, placed in the low phase of the clock.

// File: rtl/dbg_tap_pkg.sv
`timescale 1ns/1ps
package dbg_tap_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_t;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OP_EXTEST  = 4'h0;
   localparam logic [OPC_W-1:0] OP_SELECT  = 4'h2;
   localparam logic [OPC_W-1:0] OP_RESTART = 4'h4;
   localparam logic [OPC_W-1:0] OP_CLAMP   = 4'h5;
   localparam logic [OPC_W-1:0] OP_HIGHZ   = 4'h7;
   localparam logic [OPC_W-1:0] OP_CLAMPZ  = 4'h9;
   localparam logic [OPC_W-1:0] OP_INTEST  = 4'hC;
   localparam logic [OPC_W-1:0] OP_IDCODE  = 4'hE;
   localparam logic [OPC_W-1:0] OP_BYPASS  = 4'hF;

   localparam logic [OPC_W-1:0] IR_CAPTURE = 4'b0001;

   typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_SELECT, DR_CHAIN} dr_kind_t;

   // Which data register sits behind TDI/TDO for a given instruction.
   function automatic dr_kind_t pick_dr(input logic [OPC_W-1:0] op, input logic chain_ok);
      dr_kind_t k;
      case (op)
         OP_IDCODE:            k = DR_IDENT;
         OP_SELECT:            k = DR_SELECT;
         OP_INTEST, OP_EXTEST: k = chain_ok ? DR_CHAIN : DR_BYPASS;
         default:              k = DR_BYPASS;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
`timescale 1ns/1ps
module dbg_tap_fsm
   import dbg_tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t st
);

   tap_state_t nxt;

   always_comb begin
      case (st)
         TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
         TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
         TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
         TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
         TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
         TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
         TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         default:   nxt = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= TS_RESET;
      else         st <= nxt;
   end

endmodule

// File: rtl/dbg_tap_ir.sv
`timescale 1ns/1ps
module dbg_tap_ir
   import dbg_tap_pkg::*;
(
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tdi,
   input  tap_state_t       st,
   output logic [OPC_W-1:0] ir_cur,
   output logic             ir_sdo
);

   logic [OPC_W-1:0] ir_sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sh  <= IR_CAPTURE;
         ir_cur <= OP_IDCODE;
      end else begin
         case (st)
            TS_RESET:  ir_cur <= OP_IDCODE;
            TS_CAP_IR: ir_sh  <= IR_CAPTURE;
            TS_SH_IR:  ir_sh  <= {tdi, ir_sh[OPC_W-1:1]};
            TS_UPD_IR: ir_cur <= ir_sh;
            default:   ;
         endcase
      end
   end

   assign ir_sdo = ir_sh[0];

endmodule

// File: rtl/dbg_tap_dr.sv
`timescale 1ns/1ps
module dbg_tap_dr
   import dbg_tap_pkg::*;
#(
   parameter int          SEL_W    = 4,
   parameter int          DBUS_W   = 32,
   parameter int          ID_W     = 32,
   parameter logic [31:0] ID_VALUE = 32'h4A51_D2C3,
   parameter int          NUM_CH   = 3
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tdi,
   input  tap_state_t       st,
   input  logic [OPC_W-1:0] ir_cur,
   input  logic             periph_sdo,
   input  logic             dbgreg_sdo,
   output logic             dr_sdo,
   output logic [SEL_W-1:0] sel_cur,
   output logic [NUM_CH-1:0] chain_capture,
   output logic [NUM_CH-1:0] chain_shift,
   output logic [NUM_CH-1:0] chain_update
);

   localparam int               CORE_LEN    = DBUS_W + 1;
   localparam logic [SEL_W-1:0] SEL_CAPTURE = {1'b1, {(SEL_W-1){1'b0}}};
   localparam logic [SEL_W-1:0] SEL_LIMIT   = SEL_W'(NUM_CH);

   logic                 byp;
   logic [ID_W-1:0]      id_sh;
   logic [SEL_W-1:0]     sel_sh;
   logic [CORE_LEN-1:0]  core_sh;
   logic [NUM_CH-1:0]    hit;
   logic [NUM_CH-1:0]    ch_sdo;
   dr_kind_t             kind;

   assign kind = pick_dr(ir_cur, sel_cur < SEL_LIMIT);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
      assign hit[i]           = (kind == DR_CHAIN) && (sel_cur == SEL_W'(i));
      assign chain_capture[i] = hit[i] && (st == TS_CAP_DR);
      assign chain_shift[i]   = hit[i] && (st == TS_SH_DR);
      assign chain_update[i]  = hit[i] && (st == TS_UPD_DR);
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp     <= 1'b0;
         id_sh   <= ID_VALUE[ID_W-1:0];
         sel_sh  <= SEL_CAPTURE;
         sel_cur <= '0;
      end else begin
         case (st)
            TS_CAP_DR: begin
               byp <= 1'b0;
               if (kind == DR_IDENT)  id_sh  <= ID_VALUE[ID_W-1:0];
               if (kind == DR_SELECT) sel_sh <= SEL_CAPTURE;
            end
            TS_SH_DR: begin
               byp <= tdi;
               if (kind == DR_IDENT)  id_sh  <= {tdi, id_sh[ID_W-1:1]};
               if (kind == DR_SELECT) sel_sh <= {tdi, sel_sh[SEL_W-1:1]};
            end
            TS_UPD_DR: if (kind == DR_SELECT) sel_cur <= sel_sh;
            default: ;
         endcase
      end
   end

   // Core data bus chain: data bits plus the breakpoint bit, kept inside.
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)             core_sh <= '0;
      else if (chain_shift[1]) core_sh <= {tdi, core_sh[CORE_LEN-1:1]};
   end

   assign ch_sdo[0] = periph_sdo;
   assign ch_sdo[1] = core_sh[0];
   assign ch_sdo[2] = dbgreg_sdo;

   always_comb begin
      case (kind)
         DR_IDENT:  dr_sdo = id_sh[0];
         DR_SELECT: dr_sdo = sel_sh[0];
         DR_CHAIN:  dr_sdo = |(hit & ch_sdo);
         default:   dr_sdo = byp;
      endcase
   end

endmodule

// File: rtl/dbg_tap_top.sv
`timescale 1ns/1ps
module dbg_tap_top
   import dbg_tap_pkg::*;
#(
   parameter int          SEL_W    = 4,
   parameter int          DBUS_W   = 32,
   parameter logic [31:0] ID_VALUE = 32'h4A51_D2C3
) (
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   input  logic       tdi,
   input  logic       periph_sdo,
   input  logic       dbgreg_sdo,
   output logic       tdo,
   output logic       restart_req,
   output logic [2:0] chain_capture,
   output logic [2:0] chain_shift,
   output logic [2:0] chain_update
);

   localparam int NUM_CH = 3;
   localparam int ID_W   = 32;

   if (SEL_W < 2) begin : g_bad_sel
      $error("dbg_tap_top: SEL_W must hold chain numbers 0..2");
   end
   if (DBUS_W < 1) begin : g_bad_bus
      $error("dbg_tap_top: DBUS_W must be positive");
   end
   if (ID_VALUE[0] != 1'b1) begin : g_bad_id
      $error("dbg_tap_top: ID_VALUE bit 0 must be set");
   end

   tap_state_t       st;
   logic [OPC_W-1:0] ir_cur;
   logic             ir_sdo;
   logic             dr_sdo;
   logic [SEL_W-1:0] sel_cur;

   dbg_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .st     (st)
   );

   dbg_tap_ir u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .st     (st),
      .ir_cur (ir_cur),
      .ir_sdo (ir_sdo)
   );

   dbg_tap_dr #(
      .SEL_W    (SEL_W),
      .DBUS_W   (DBUS_W),
      .ID_W     (ID_W),
      .ID_VALUE (ID_VALUE),
      .NUM_CH   (NUM_CH)
   ) u_dr (
      .tck           (tck),
      .trst_n        (trst_n),
      .tdi           (tdi),
      .st            (st),
      .ir_cur        (ir_cur),
      .periph_sdo    (periph_sdo),
      .dbgreg_sdo    (dbgreg_sdo),
      .dr_sdo        (dr_sdo),
      .sel_cur       (sel_cur),
      .chain_capture (chain_capture),
      .chain_shift   (chain_shift),
      .chain_update  (chain_update)
   );

   assign restart_req = (st == TS_IDLE) && (ir_cur == OP_RESTART);

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)              tdo <= 1'b0;
      else if (st == TS_SH_IR)  tdo <= ir_sdo;
      else if (st == TS_SH_DR)  tdo <= dr_sdo;
      else                      tdo <= 1'b0;
   end

endmodule

// File: rtl/dbg_tap_chk.sv
`timescale 1ns/1ps
module dbg_tap_chk
   import dbg_tap_pkg::*;
#(
   parameter int SEL_W = 4
) (
   input logic             tck,
   input logic             trst_n,
   input logic             tms,
   input tap_state_t       st,
   input logic [OPC_W-1:0] ir_cur,
   input logic [SEL_W-1:0] sel_cur,
   input logic             restart_req,
   input logic [2:0]       chain_capture,
   input logic [2:0]       chain_shift,
   input logic [2:0]       chain_update
);

   // R8
   strobe_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({chain_capture, chain_shift, chain_update}));

   // R8
   cap_to_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
      ((|chain_capture) && !tms) |=> (chain_shift == $past(chain_capture)));

   // R9
   restart_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (restart_req && !tms) |=> restart_req);

   // R4
   sel_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st != TS_UPD_DR) |=> $stable(sel_cur));

   // R2
   reset_ir_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_RESET) |=> (ir_cur == OP_IDCODE));

   // R1
   ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      ((st != TS_UPD_IR) && (st != TS_RESET)) |=> $stable(ir_cur));

   // R5
   chain_instr_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (|chain_shift) |-> ((ir_cur == OP_INTEST) || (ir_cur == OP_EXTEST)));

endmodule

bind dbg_tap_top dbg_tap_chk #(.SEL_W(SEL_W)) u_chk (
   .tck           (tck),
   .trst_n        (trst_n),
   .tms           (tms),
   .st            (st),
   .ir_cur        (ir_cur),
   .sel_cur       (sel_cur),
   .restart_req   (restart_req),
   .chain_capture (chain_capture),
   .chain_shift   (chain_shift),
   .chain_update  (chain_update)
);

// File: tb/dbg_tap_top_test.sv
`timescale 1ns/100ps
module dbg_tap_top_test;

   localparam logic [31:0] ID = 32'h4A51_D2C3;

   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic       tms = 1'b1;
   logic       tdi = 1'b0;
   logic       periph_sdo = 1'b0;
   logic       dbgreg_sdo = 1'b0;
   logic       tdo;
   logic       restart_req;
   logic [2:0] chain_capture, chain_shift, chain_update;

   int total = 0;
   int bad = 0;
   bit done = 0;
   int cap_n[3], sh_n[3], up_n[3];
   int rst_n_cnt = 0;
   int rise_moves = 0;

   string       exp_tag[$];
   logic [63:0] exp_val[$];
   logic [63:0] act_val[$];

   always #2.5 tck = ~tck;

   dbg_tap_top uut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .periph_sdo(periph_sdo), .dbgreg_sdo(dbgreg_sdo),
      .tdo(tdo), .restart_req(restart_req),
      .chain_capture(chain_capture), .chain_shift(chain_shift), .chain_update(chain_update)
   );

   // R11: tdo must never move while tck is high
   always @(tdo) if (tck === 1'b1) rise_moves++;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic sb_expect(input string tag, input logic [63:0] v);
      exp_tag.push_back(tag);
      exp_val.push_back(v);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge tck);
         while (act_val.size() > 0) begin
            logic [63:0] a;
            a = act_val.pop_front();
            if (exp_tag.size() == 0) chk("scoreboard-extra", a, 64'h0);
            else chk(exp_tag.pop_front(), a, exp_val.pop_front());
         end
      end
   end

   task automatic clr_counts();
      for (int i = 0; i < 3; i++) begin cap_n[i] = 0; sh_n[i] = 0; up_n[i] = 0; end
      rst_n_cnt = 0;
   endtask

   task automatic step(input logic m, input logic d, output logic o);
      @(negedge tck);
      #0.5 tms = m; tdi = d;
      #1 o = tdo;
      for (int i = 0; i < 3; i++) begin
         cap_n[i] += int'(chain_capture[i]);
         sh_n[i]  += int'(chain_shift[i]);
         up_n[i]  += int'(chain_update[i]);
      end
      rst_n_cnt += int'(restart_req);
   endtask

   task automatic idle(input int n, output logic o);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
   endtask

   task automatic tms_reset();
      logic o;
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
   endtask

   task automatic load_ir(input logic [3:0] code, output logic [3:0] cap);
      logic o;
      step(1'b1, 1'b0, o); step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
      for (int i = 0; i < 4; i++) begin
         step(i == 3, code[i], o);
         cap[i] = o;
      end
      step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
   endtask

   task automatic scan_dr(input int n, input logic [63:0] din);
      logic o;
      logic [63:0] dout = '0;
      step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], o);
         dout[i] = o;
      end
      step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
      act_val.push_back(dout);
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] cap;
      logic o;
      logic [63:0] a1 = 64'h0_1234_5679;
      logic [63:0] a2 = 64'h1_8765_4321;
      logic [3:0] odd_codes[5] = '{4'h5, 4'h7, 4'h9, 4'h4, 4'h3};

      // reset state
      repeat (3) @(negedge tck);
      #1;
      chk("R11 tdo in reset", {63'd0, tdo}, 64'd0);
      chk("R9 restart in reset", {63'd0, restart_req}, 64'd0);
      chk("R8 strobes in reset", {55'd0, chain_capture, chain_shift, chain_update}, 64'd0);
      @(negedge tck); #0.5 trst_n = 1'b1;
      step(1'b0, 1'b0, o);

      // R2: IDCODE current after reset
      sb_expect("R2 idcode after trst", {32'd0, ID});
      scan_dr(32, 64'd0);

      // R1: capture pattern, R3: bypass
      load_ir(4'hF, cap);
      chk("R1 ir capture", {60'd0, cap}, 64'h1);
      sb_expect("R3 bypass 0xF", 64'h6A);
      scan_dr(8, 64'hB5);
      for (int k = 0; k < 5; k++) begin
         load_ir(odd_codes[k], cap);
         sb_expect($sformatf("R3 bypass code %h", odd_codes[k]), 64'h78);
         scan_dr(8, 64'h3C);
      end

      // R10/R7/R8: after trst select is 0 -> periphery chain
      periph_sdo = 1'b1;
      load_ir(4'hC, cap);
      clr_counts();
      sb_expect("R7 chain0 follows periph_sdo", 64'hFF);
      scan_dr(8, 64'h00);
      chk("R8 chain0 capture count", 64'(cap_n[0]), 64'd1);
      chk("R8 chain0 shift count", 64'(sh_n[0]), 64'd8);
      chk("R8 chain0 update count", 64'(up_n[0]), 64'd1);
      chk("R8 other chains quiet", 64'(sh_n[1] + sh_n[2] + cap_n[1] + cap_n[2]), 64'd0);
      periph_sdo = 1'b0;

      // R4: select chain 1, R6: 33-bit length
      load_ir(4'h2, cap);
      sb_expect("R4 select capture", 64'h8);
      scan_dr(4, 64'h1);
      load_ir(4'hC, cap);
      clr_counts();
      sb_expect("R6 chain1 first pass", 64'h0);
      scan_dr(33, a1);
      sb_expect("R6 chain1 second pass", a1);
      scan_dr(33, a2);
      chk("R8 chain1 shift count", 64'(sh_n[1]), 64'd66);

      // R4: select held across other instructions
      load_ir(4'hE, cap);
      sb_expect("R2 idcode again", {32'd0, ID});
      scan_dr(32, 64'd0);
      load_ir(4'hC, cap);
      sb_expect("R4 select retained, chain1 data", a2);
      scan_dr(33, 64'd0);

      // R5/R7: chain 2 via EXTEST
      load_ir(4'h2, cap);
      sb_expect("R4 select capture 2", 64'h8);
      scan_dr(4, 64'h2);
      dbgreg_sdo = 1'b1;
      load_ir(4'h0, cap);
      clr_counts();
      sb_expect("R7 chain2 follows dbgreg_sdo", 64'hFF);
      scan_dr(8, 64'h00);
      chk("R5 chain2 shift count", 64'(sh_n[2]), 64'd8);

      // R10: TMS reset keeps select, R2 IDCODE current
      tms_reset();
      sb_expect("R2 idcode after tms reset", {32'd0, ID});
      scan_dr(32, 64'd0);
      load_ir(4'hC, cap);
      sb_expect("R10 select kept through tms reset", 64'hFF);
      scan_dr(8, 64'h00);
      dbgreg_sdo = 1'b0;

      // R5: out-of-range select behaves as bypass
      load_ir(4'h2, cap);
      sb_expect("R4 select capture 5", 64'h8);
      scan_dr(4, 64'h5);
      load_ir(4'hC, cap);
      clr_counts();
      sb_expect("R5 unmapped select bypass", 64'h6A);
      scan_dr(8, 64'hB5);
      chk("R5 no strobes for unmapped select",
          64'(cap_n[0]+cap_n[1]+cap_n[2]+sh_n[0]+sh_n[1]+sh_n[2]+up_n[0]+up_n[1]+up_n[2]), 64'd0);

      // R9: restart request in idle
      load_ir(4'h4, cap);
      clr_counts();
      idle(3, o);
      chk("R9 restart pulses in idle", 64'(rst_n_cnt), 64'd3);
      chk("R11 tdo low in idle", {63'd0, o}, 64'd0);
      load_ir(4'hE, cap);
      clr_counts();
      idle(4, o);
      chk("R9 no restart under idcode", 64'(rst_n_cnt), 64'd0);

      // R10: trst clears select (set to 2 first)
      load_ir(4'h2, cap);
      sb_expect("R4 select capture before trst", 64'h8);
      scan_dr(4, 64'h2);
      @(negedge tck); #0.5 trst_n = 1'b0;
      #1 chk("R11 tdo cleared by trst", {63'd0, tdo}, 64'd0);
      @(negedge tck); #0.5 trst_n = 1'b1;
      step(1'b0, 1'b0, o);
      periph_sdo = 1'b1;
      load_ir(4'hC, cap);
      sb_expect("R10 trst clears select", 64'hFF);
      scan_dr(8, 64'h00);
      periph_sdo = 1'b0;

      repeat (3) @(negedge tck);
      chk("R11 tdo moves only on falling edge", 64'(rise_moves), 64'd0);
      chk("scoreboard drained", 64'(exp_tag.size()), 64'd0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule